// File: doc/BRIEF.md
# DMA Channel Register File

This block is the software-visible register set of a four-channel DMA controller, reached through an 8-bit I/O port with a small offset decoder. Every channel owns a 16-bit address and a 16-bit transfer count, each kept as a base copy and a current copy. Software reaches these 16-bit registers one byte at a time. A single byte pointer, shared by all channels, decides whether an access lands on the low byte or the high byte.

The upper half of the offset space holds the control ports. These are the command, request, single-channel mask, mode, pointer-clear, master-clear, clear-all-masks and write-all-masks ports. Several of them carry the channel number inside the data byte rather than in the offset. The status register and the temporary register are read back from the same space.

A transfer engine beside this block reads the masks, modes and programmed values. The engine writes back current address and count, reports terminal count, and loads the temporary register. Arbitration and memory cycles belong to the engine.

Top module: `dma_regfile`

## Requirements
- R1: After reset all four mask bits are set, the byte pointer selects the low byte, and every address, count, mode, command, request, status, temporary and read-data register is zero.
- R2: Offset 2n is the address register of channel n and offset 2n+1 its count register. A write updates the addressed byte of both the base and the current copy. A read returns that byte of the current copy.
- R3: One byte pointer serves all channels. It starts on the low byte and flips after every read or write to offsets 0x0 to 0x7.
- R4: Any write to offset 0xC returns the byte pointer to the low byte, whatever the data.
- R5: A write to offset 0xA changes one mask bit. Data bits 1:0 name the channel, and data bit 2 gives the new mask value (1 masks, 0 unmasks).
- R6: A write to offset 0xE clears all four masks. A write to offset 0xF loads all four masks from data bits 3:0, with bit n for channel n.
- R7: A write to offset 0xB stores data bits 7:2 as the 6-bit mode field of the channel named by data bits 1:0. Channel n's field sits at `ch_mode[6n+5:6n]`. Mode field bit 2 (data bit 4) is auto-initialize, and data 0xC0 plus the channel gives cascade mode.
- R8: A write to offset 0x8 loads the command register. A write to offset 0x9 sets (data bit 2 = 1) or clears the request bit of the channel in data bits 1:0. The request bits appear on `req_pend`.
- R9: A read of offset 0x8 returns the request bits in bits 7:4 and the terminal-count flags in bits 3:0, then clears the flags. A terminal count reported in the same cycle as that read is not lost.
- R10: A write to offset 0xD sets all masks and clears the byte pointer, command, request, status and temporary registers. It leaves addresses, counts and modes unchanged. A read of offset 0xD returns the temporary register, which the engine loads through `eng_temp_we`.
- R11: An engine update overwrites the current address and count of `eng_ch`. The base copies stay unchanged. With `eng_tc` the update also sets that channel's terminal-count flag. If the channel's auto-initialize bit is set, the current copies are instead reloaded from the base copies.
- R12: `io_rdata` is registered. It changes on the clock edge that samples a read strobe (a read with no write strobe) and holds its value otherwise. Reads of offsets 0x9, 0xA, 0xB, 0xC, 0xE and 0xF return zero.
- R13: When a software write and an engine update hit the same channel register in one cycle, the engine value is taken first and then the written byte replaces its byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 4 | Port offset |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |
| eng_upd | input | 1 | Engine writes back current address and count |
| eng_ch | input | 2 | Channel of the engine update |
| eng_addr | input | 16 | Updated current address |
| eng_cnt | input | 16 | Updated current count |
| eng_tc | input | 1 | Terminal count reached, qualified by eng_upd |
| eng_temp_we | input | 1 | Load temporary register |
| eng_temp | input | 8 | Temporary register data |
| ch_mask | output | 4 | Mask bit per channel |
| ch_mode | output | 24 | Mode fields, 6 bits per channel |
| base_addr | output | 64 | Base addresses, 16 bits per channel |
| base_cnt | output | 64 | Base counts, 16 bits per channel |
| cur_addr | output | 64 | Current addresses, 16 bits per channel |
| cur_cnt | output | 64 | Current counts, 16 bits per channel |
| cmd_reg | output | 8 | Command register |
| req_pend | output | 4 | Software request bits |

## Verification
Two pairs of events can fall in the same clock cycle. In the first pair, the engine reports terminal count in the very cycle that software reads the status register. The bench provokes this by driving `eng_tc` together with the status read strobe. It then checks that the returned byte omits the new flag and that the next status read shows it. In the second pair, a byte write to a channel address lands in the same cycle as an engine update of that channel. The bench judges this case against its reference model, which merges the written byte over the engine value.

// File: rtl/dma_rf_pkg.sv
package dma_rf_pkg;

  localparam logic [3:0] OFF_CMD     = 4'h8;
  localparam logic [3:0] OFF_REQ     = 4'h9;
  localparam logic [3:0] OFF_MASK1   = 4'hA;
  localparam logic [3:0] OFF_MODE    = 4'hB;
  localparam logic [3:0] OFF_PTRCLR  = 4'hC;
  localparam logic [3:0] OFF_MCLR    = 4'hD;
  localparam logic [3:0] OFF_UNMASK  = 4'hE;
  localparam logic [3:0] OFF_MASKALL = 4'hF;

  // auto-initialize position inside the stored mode field
  localparam int AUTO_BIT = 2;

  typedef struct packed {
    logic cmd_wr;
    logic req_wr;
    logic mask1_wr;
    logic mode_wr;
    logic ptrclr_wr;
    logic mclr_wr;
    logic unmask_wr;
    logic maskall_wr;
    logic stat_rd;
    logic temp_rd;
  } ctl_strobe_t;

endpackage

// File: rtl/dma_rf_decode.sv
module dma_rf_decode
  import dma_rf_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 4
) (
  input  logic [AW-1:0]          io_addr,
  input  logic                   io_wr,
  input  logic                   io_rd,
  output logic                   chan_wr,
  output logic                   chan_rd,
  output logic                   cnt_sel,
  output logic [$clog2(NCH)-1:0] chan_idx,
  output ctl_strobe_t            st
);
  localparam int CHW = $clog2(NCH);
  localparam logic [AW-1:0] SPAN = AW'(2 * NCH);

  logic rd_only;
  logic chan_hit;

  always_comb begin
    rd_only  = io_rd & ~io_wr;
    chan_hit = io_addr < SPAN;
    chan_wr  = io_wr & chan_hit;
    chan_rd  = rd_only & chan_hit;
    cnt_sel  = io_addr[0];
    chan_idx = io_addr[CHW:1];

    st.cmd_wr     = io_wr   && (io_addr == AW'(OFF_CMD));
    st.req_wr     = io_wr   && (io_addr == AW'(OFF_REQ));
    st.mask1_wr   = io_wr   && (io_addr == AW'(OFF_MASK1));
    st.mode_wr    = io_wr   && (io_addr == AW'(OFF_MODE));
    st.ptrclr_wr  = io_wr   && (io_addr == AW'(OFF_PTRCLR));
    st.mclr_wr    = io_wr   && (io_addr == AW'(OFF_MCLR));
    st.unmask_wr  = io_wr   && (io_addr == AW'(OFF_UNMASK));
    st.maskall_wr = io_wr   && (io_addr == AW'(OFF_MASKALL));
    st.stat_rd    = rd_only && (io_addr == AW'(OFF_CMD));
    st.temp_rd    = rd_only && (io_addr == AW'(OFF_MCLR));
  end

endmodule

// File: rtl/dma_rf_chan.sv
module dma_rf_chan #(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_addr,
  input  logic            wr_cnt,
  input  logic            hi,
  input  logic [DW-1:0]   wdata,
  input  logic            upd,
  input  logic [2*DW-1:0] upd_addr,
  input  logic [2*DW-1:0] upd_cnt,
  input  logic            reload,
  output logic [2*DW-1:0] base_addr,
  output logic [2*DW-1:0] base_cnt,
  output logic [2*DW-1:0] cur_addr,
  output logic [2*DW-1:0] cur_cnt
);
  localparam int RW = 2 * DW;

  function automatic logic [RW-1:0] put_byte(input logic [RW-1:0] v,
                                             input logic h,
                                             input logic [DW-1:0] b);
    put_byte = h ? {b, v[DW-1:0]} : {v[RW-1:DW], b};
  endfunction

  logic [RW-1:0] ba_q, bc_q, ca_q, cc_q;
  logic [RW-1:0] ca_eng, cc_eng;

  // engine result first; a software byte then lands on top of it
  always_comb begin
    ca_eng = reload ? ba_q : (upd ? upd_addr : ca_q);
    cc_eng = reload ? bc_q : (upd ? upd_cnt  : cc_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ba_q <= '0;
      bc_q <= '0;
      ca_q <= '0;
      cc_q <= '0;
    end else begin
      ba_q <= wr_addr ? put_byte(ba_q, hi, wdata) : ba_q;
      bc_q <= wr_cnt  ? put_byte(bc_q, hi, wdata) : bc_q;
      ca_q <= wr_addr ? put_byte(ca_eng, hi, wdata) : ca_eng;
      cc_q <= wr_cnt  ? put_byte(cc_eng, hi, wdata) : cc_eng;
    end
  end

  assign base_addr = ba_q;
  assign base_cnt  = bc_q;
  assign cur_addr  = ca_q;
  assign cur_cnt   = cc_q;

endmodule

// File: rtl/dma_rf_ctrl.sv
module dma_rf_ctrl #(
  parameter int NCH = 4,
  parameter int DW  = 8
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               cmd_wr,
  input  logic                               req_wr,
  input  logic                               mask1_wr,
  input  logic                               mode_wr,
  input  logic                               ptrclr_wr,
  input  logic                               mclr_wr,
  input  logic                               unmask_wr,
  input  logic                               maskall_wr,
  input  logic                               stat_rd,
  input  logic                               chan_acc,
  input  logic [DW-1:0]                      wdata,
  input  logic                               eng_upd,
  input  logic [$clog2(NCH)-1:0]             eng_ch,
  input  logic                               eng_tc,
  input  logic                               eng_temp_we,
  input  logic [DW-1:0]                      eng_temp,
  output logic                               ptr_hi,
  output logic [NCH-1:0]                     mask,
  output logic [NCH*(DW-$clog2(NCH))-1:0]    mode,
  output logic [DW-1:0]                      cmd,
  output logic [NCH-1:0]                     req,
  output logic [NCH-1:0]                     tc,
  output logic [DW-1:0]                      temp
);
  localparam int CHW = $clog2(NCH);
  localparam int MW  = DW - CHW;
  localparam logic [NCH-1:0] ONE = NCH'(1);

  logic [MW-1:0]  mode_q [NCH];
  logic [NCH-1:0] sel_bit, tc_set;
  logic           flag;

  always_comb begin
    sel_bit = ONE << wdata[CHW-1:0];
    flag    = wdata[CHW];
    tc_set  = (eng_upd && eng_tc) ? (ONE << eng_ch) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst || mclr_wr) begin
      ptr_hi <= 1'b0;
      mask   <= '1;
      cmd    <= '0;
      req    <= '0;
      tc     <= '0;
      temp   <= '0;
    end else begin
      if (ptrclr_wr)     ptr_hi <= 1'b0;
      else if (chan_acc) ptr_hi <= ~ptr_hi;

      if (unmask_wr)       mask <= '0;
      else if (maskall_wr) mask <= wdata[NCH-1:0];
      else if (mask1_wr)   mask <= flag ? (mask | sel_bit) : (mask & ~sel_bit);

      if (cmd_wr) cmd <= wdata;
      if (req_wr) req <= flag ? (req | sel_bit) : (req & ~sel_bit);

      // a flag raised in the reading cycle survives the clear
      tc <= (stat_rd ? '0 : tc) | tc_set;

      if (eng_temp_we) temp <= eng_temp;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NCH; i++) mode_q[i] <= '0;
    end else if (mode_wr) begin
      mode_q[wdata[CHW-1:0]] <= wdata[DW-1:CHW];
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_mode
    assign mode[g*MW +: MW] = mode_q[g];
  end

endmodule

// File: rtl/dma_regfile.sv
module dma_regfile
  import dma_rf_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = 8,
  parameter int AW  = 4
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [AW-1:0]                    io_addr,
  input  logic                             io_wr,
  input  logic                             io_rd,
  input  logic [DW-1:0]                    io_wdata,
  output logic [DW-1:0]                    io_rdata,
  input  logic                             eng_upd,
  input  logic [$clog2(NCH)-1:0]           eng_ch,
  input  logic [2*DW-1:0]                  eng_addr,
  input  logic [2*DW-1:0]                  eng_cnt,
  input  logic                             eng_tc,
  input  logic                             eng_temp_we,
  input  logic [DW-1:0]                    eng_temp,
  output logic [NCH-1:0]                   ch_mask,
  output logic [NCH*(DW-$clog2(NCH))-1:0]  ch_mode,
  output logic [NCH*2*DW-1:0]              base_addr,
  output logic [NCH*2*DW-1:0]              base_cnt,
  output logic [NCH*2*DW-1:0]              cur_addr,
  output logic [NCH*2*DW-1:0]              cur_cnt,
  output logic [DW-1:0]                    cmd_reg,
  output logic [NCH-1:0]                   req_pend
);
  localparam int RW  = 2 * DW;
  localparam int CHW = $clog2(NCH);
  localparam int MW  = DW - CHW;

  logic            chan_wr, chan_rd, cnt_sel;
  logic [CHW-1:0]  chan_idx;
  ctl_strobe_t     st;
  logic            ptr_hi;
  logic [NCH-1:0]  tc;
  logic [DW-1:0]   temp;
  logic [DW-1:0]   rdata_q;
  logic [RW-1:0]   rd_word;

  dma_rf_decode #(.NCH(NCH), .AW(AW)) u_dec (
    .io_addr (io_addr),
    .io_wr   (io_wr),
    .io_rd   (io_rd),
    .chan_wr (chan_wr),
    .chan_rd (chan_rd),
    .cnt_sel (cnt_sel),
    .chan_idx(chan_idx),
    .st      (st)
  );

  dma_rf_ctrl #(.NCH(NCH), .DW(DW)) u_ctl (
    .clk        (clk),
    .rst        (rst),
    .cmd_wr     (st.cmd_wr),
    .req_wr     (st.req_wr),
    .mask1_wr   (st.mask1_wr),
    .mode_wr    (st.mode_wr),
    .ptrclr_wr  (st.ptrclr_wr),
    .mclr_wr    (st.mclr_wr),
    .unmask_wr  (st.unmask_wr),
    .maskall_wr (st.maskall_wr),
    .stat_rd    (st.stat_rd),
    .chan_acc   (chan_wr | chan_rd),
    .wdata      (io_wdata),
    .eng_upd    (eng_upd),
    .eng_ch     (eng_ch),
    .eng_tc     (eng_tc),
    .eng_temp_we(eng_temp_we),
    .eng_temp   (eng_temp),
    .ptr_hi     (ptr_hi),
    .mask       (ch_mask),
    .mode       (ch_mode),
    .cmd        (cmd_reg),
    .req        (req_pend),
    .tc         (tc),
    .temp       (temp)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic hit, upd;
    assign hit = chan_wr && (chan_idx == CHW'(g));
    assign upd = eng_upd && (eng_ch == CHW'(g));

    dma_rf_chan #(.DW(DW)) u_ch (
      .clk      (clk),
      .rst      (rst),
      .wr_addr  (hit && !cnt_sel),
      .wr_cnt   (hit && cnt_sel),
      .hi       (ptr_hi),
      .wdata    (io_wdata),
      .upd      (upd),
      .upd_addr (eng_addr),
      .upd_cnt  (eng_cnt),
      .reload   (upd && eng_tc && ch_mode[g*MW + AUTO_BIT]),
      .base_addr(base_addr[g*RW +: RW]),
      .base_cnt (base_cnt[g*RW +: RW]),
      .cur_addr (cur_addr[g*RW +: RW]),
      .cur_cnt  (cur_cnt[g*RW +: RW])
    );
  end

  always_comb begin
    rd_word = cnt_sel ? cur_cnt[chan_idx*RW +: RW] : cur_addr[chan_idx*RW +: RW];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (chan_rd) begin
      rdata_q <= ptr_hi ? rd_word[RW-1:DW] : rd_word[DW-1:0];
    end else if (st.stat_rd) begin
      rdata_q <= DW'({req_pend, tc});
    end else if (st.temp_rd) begin
      rdata_q <= temp;
    end else if (io_rd && !io_wr) begin
      rdata_q <= '0;
    end
  end

  assign io_rdata = rdata_q;

endmodule

// File: rtl/dma_regfile_chk.sv
module dma_regfile_chk #(
  parameter int NCH = 4,
  parameter int DW  = 8,
  parameter int AW  = 4
) (
  input logic                   clk,
  input logic                   rst,
  input logic [AW-1:0]          io_addr,
  input logic                   io_wr,
  input logic                   io_rd,
  input logic [DW-1:0]          io_wdata,
  input logic                   eng_upd,
  input logic [$clog2(NCH)-1:0] eng_ch,
  input logic                   eng_tc,
  input logic [NCH-1:0]         ch_mask,
  input logic [NCH*2*DW-1:0]    base_addr,
  input logic [NCH*2*DW-1:0]    cur_addr,
  input logic                   ptr_hi,
  input logic [NCH-1:0]         tc
);
  localparam logic [AW-1:0] SPAN = AW'(2 * NCH);

  logic chan_acc, mclr;
  assign chan_acc = (io_wr || io_rd) && (io_addr < SPAN);
  assign mclr     = io_wr && (io_addr == AW'(4'hD));

  assert_load_both_R2: assert property (@(posedge clk) disable iff (rst)
    (io_wr && io_addr == '0 && !ptr_hi && !eng_upd)
    |=> (base_addr[DW-1:0] == $past(io_wdata)) && (cur_addr[DW-1:0] == $past(io_wdata)));

  assert_ptr_flip_R3: assert property (@(posedge clk) disable iff (rst)
    chan_acc |=> (ptr_hi != $past(ptr_hi)));

  assert_ptr_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (io_wr && io_addr == AW'(4'hC)) |=> !ptr_hi);

  assert_clear_masks_R6: assert property (@(posedge clk) disable iff (rst)
    (io_wr && io_addr == AW'(4'hE)) |=> (ch_mask == '0));

  assert_tc_kept_R9: assert property (@(posedge clk) disable iff (rst)
    (eng_upd && eng_tc && !mclr) |=> tc[$past(eng_ch)]);

  assert_master_clear_R10: assert property (@(posedge clk) disable iff (rst)
    mclr |=> ((&ch_mask) && !ptr_hi && (tc == '0)));

endmodule

bind dma_regfile dma_regfile_chk #(.NCH(NCH), .DW(DW), .AW(AW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .io_addr  (io_addr),
  .io_wr    (io_wr),
  .io_rd    (io_rd),
  .io_wdata (io_wdata),
  .eng_upd  (eng_upd),
  .eng_ch   (eng_ch),
  .eng_tc   (eng_tc),
  .ch_mask  (ch_mask),
  .base_addr(base_addr),
  .cur_addr (cur_addr),
  .ptr_hi   (ptr_hi),
  .tc       (tc)
);

// File: tb/dma_regfile_bench.sv
module dma_regfile_bench;
  localparam int PERIOD = 10;

  logic        clk = 0;
  logic        rst = 1;
  logic [3:0]  io_addr = 0;
  logic        io_wr = 0, io_rd = 0;
  logic [7:0]  io_wdata = 0;
  logic [7:0]  io_rdata;
  logic        eng_upd = 0;
  logic [1:0]  eng_ch = 0;
  logic [15:0] eng_addr = 0, eng_cnt = 0;
  logic        eng_tc = 0, eng_temp_we = 0;
  logic [7:0]  eng_temp = 0;
  logic [3:0]  ch_mask;
  logic [23:0] ch_mode;
  logic [63:0] base_addr, base_cnt, cur_addr, cur_cnt;
  logic [7:0]  cmd_reg;
  logic [3:0]  req_pend;

  dma_regfile u_dma_regfile (.*);

  always #(PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model state
  int m_ba[4], m_bc[4], m_ca[4], m_cc[4], m_mode[4];
  int m_mask, m_ptr, m_cmd, m_req, m_tc, m_temp, m_rdata;

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_step();
    int a, d, ch, v, nr, tcn, tmpn, ptrn;
    if (rst) begin
      for (int i = 0; i < 4; i++) begin
        m_ba[i] = 0; m_bc[i] = 0; m_ca[i] = 0; m_cc[i] = 0; m_mode[i] = 0;
      end
      m_mask = 15; m_ptr = 0; m_cmd = 0; m_req = 0; m_tc = 0; m_temp = 0; m_rdata = 0;
      return;
    end
    a = io_addr; d = io_wdata; nr = m_rdata; tcn = m_tc; ptrn = m_ptr;
    tmpn = eng_temp_we ? eng_temp : m_temp;
    if (io_rd && !io_wr) begin
      if (a < 8) begin
        v = (a & 1) ? m_cc[a >> 1] : m_ca[a >> 1];
        nr = m_ptr ? (v >> 8) & 255 : v & 255;
        ptrn ^= 1;
      end else if (a == 8) begin
        nr = (m_req << 4) | m_tc;
        tcn = 0;
      end else if (a == 13) nr = m_temp;
      else nr = 0;
    end
    if (eng_upd) begin
      ch = eng_ch;
      if (eng_tc && ((m_mode[ch] >> 2) & 1)) begin
        m_ca[ch] = m_ba[ch]; m_cc[ch] = m_bc[ch];
      end else begin
        m_ca[ch] = eng_addr; m_cc[ch] = eng_cnt;
      end
      if (eng_tc) tcn |= 1 << ch;
    end
    if (io_wr) begin
      if (a < 8) begin
        ch = a >> 1;
        if (a & 1) begin
          m_bc[ch] = m_ptr ? (m_bc[ch] & 255) | (d << 8) : (m_bc[ch] & 'hFF00) | d;
          m_cc[ch] = m_ptr ? (m_cc[ch] & 255) | (d << 8) : (m_cc[ch] & 'hFF00) | d;
        end else begin
          m_ba[ch] = m_ptr ? (m_ba[ch] & 255) | (d << 8) : (m_ba[ch] & 'hFF00) | d;
          m_ca[ch] = m_ptr ? (m_ca[ch] & 255) | (d << 8) : (m_ca[ch] & 'hFF00) | d;
        end
        ptrn ^= 1;
      end else case (a)
        8:  m_cmd = d;
        9:  m_req = (d & 4) ? (m_req | (1 << (d & 3))) : (m_req & ~(1 << (d & 3)));
        10: m_mask = (d & 4) ? (m_mask | (1 << (d & 3))) : (m_mask & ~(1 << (d & 3)));
        11: m_mode[d & 3] = d >> 2;
        12: ptrn = 0;
        13: begin m_mask = 15; ptrn = 0; m_cmd = 0; tcn = 0; m_req = 0; tmpn = 0; end
        14: m_mask = 0;
        default: m_mask = d & 15;
      endcase
    end
    m_rdata = nr; m_tc = tcn; m_temp = tmpn; m_ptr = ptrn & 1;
  endtask

  task automatic compare_all();
    chk(io_rdata, m_rdata, "R12 io_rdata");
    chk(ch_mask, m_mask, "R5/R6 ch_mask");
    chk(cmd_reg, m_cmd, "R8 cmd_reg");
    chk(req_pend, m_req, "R8 req_pend");
    for (int i = 0; i < 4; i++) begin
      chk(ch_mode[i*6 +: 6], m_mode[i], "R7 ch_mode");
      chk(base_addr[i*16 +: 16], m_ba[i], "R2 base_addr");
      chk(base_cnt[i*16 +: 16], m_bc[i], "R2 base_cnt");
      chk(cur_addr[i*16 +: 16], m_ca[i], "R11 cur_addr");
      chk(cur_cnt[i*16 +: 16], m_cc[i], "R11 cur_cnt");
    end
  endtask

  // inputs are applied at the falling edge; results compared at the next one
  task automatic cyc(input bit w, input bit r, input int a, input int d);
    io_wr = w; io_rd = r; io_addr = 4'(a); io_wdata = 8'(d);
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
    io_wr = 0; io_rd = 0;
    eng_upd = 0; eng_tc = 0; eng_temp_we = 0;
  endtask

  task automatic wr(input int a, input int d); cyc(1, 0, a, d); endtask
  task automatic rd(input int a); cyc(0, 1, a, 0); endtask

  task automatic eng(input int ch, input int ad, input int cn, input bit t);
    eng_upd = 1; eng_ch = 2'(ch); eng_addr = 16'(ad); eng_cnt = 16'(cn); eng_tc = t;
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    cyc(0, 0, 0, 0);
    cyc(0, 0, 0, 0);
    rst = 0;
    cyc(0, 0, 0, 0);
    // R1: reset values
    chk(ch_mask, 4'hF, "R1 masks after reset");
    chk(io_rdata, 0, "R1 rdata after reset");
    chk(cur_cnt[15:0], 0, "R1 count after reset");

    // R2: program channel 0 and read back
    wr(0, 'h34); wr(0, 'h12); wr(1, 'hFF); wr(1, 'h00);
    chk(base_addr[15:0], 'h1234, "R2 ch0 base address");
    chk(cur_cnt[15:0], 'h00FF, "R2 ch0 current count");
    rd(0); chk(io_rdata, 'h34, "R3 low byte first");
    rd(0); chk(io_rdata, 'h12, "R3 high byte second");
    rd(1); chk(io_rdata, 'hFF, "R2 count low byte read");
    rd(1);

    // R3: pointer shared across channels
    wr(2, 'h77); wr(4, 'h99);
    chk(base_addr[47:32], 'h9900, "R3 shared pointer lands on ch2 high");

    // R4: pointer clear
    wr(2, 'h55); wr(12, 'hFF); wr(2, 'h66);
    chk(base_addr[31:16], 'h0066, "R4 pointer cleared to low byte");
    wr(12, 0);

    // R5 and R6: masks
    wr(10, 'h01); chk(ch_mask, 4'hD, "R5 unmask ch1");
    wr(10, 'h05); chk(ch_mask, 4'hF, "R5 mask ch1");
    wr(15, 'h0A); chk(ch_mask, 4'hA, "R6 write all masks");
    wr(14, 'hFF); chk(ch_mask, 4'h0, "R6 clear all masks");

    // R7: modes
    wr(11, 'hC3); chk(ch_mode[23:18], 'h30, "R7 cascade mode ch3");
    wr(11, 'h55); chk(ch_mode[11:6], 'h15, "R7 auto-init mode ch1");

    // R8: command and request
    wr(8, 'h5A); chk(cmd_reg, 'h5A, "R8 command");
    wr(9, 'h06); chk(req_pend, 4'h4, "R8 request ch2");
    wr(9, 'h03); wr(9, 'h07); wr(9, 'h03);
    chk(req_pend, 4'h4, "R8 request set then clear ch3");

    // R11: engine updates
    wr(2, 'hCD); wr(2, 'hAB); wr(3, 'h10); wr(3, 'h00);
    eng(0, 'h2000, 'h0005, 0); cyc(0, 0, 0, 0);
    chk(cur_addr[15:0], 'h2000, "R11 engine current address");
    chk(base_addr[15:0], 'h1234, "R11 base unchanged");
    eng(1, 'hFFFF, 'hFFFF, 1); cyc(0, 0, 0, 0);
    chk(cur_addr[31:16], 'hABCD, "R11 auto-init reload address");
    chk(cur_cnt[31:16], 'h0010, "R11 auto-init reload count");

    // R9: status read with same-cycle terminal count
    eng(3, 'h0100, 'h0000, 1); rd(8);
    chk(io_rdata, 'h42, "R9 status before new flag");
    rd(8); chk(io_rdata, 'h48, "R9 flag raised during read kept");
    rd(8); chk(io_rdata, 'h40, "R9 flags cleared by read");

    // R13: software byte over engine update
    eng(0, 'h3344, 'h0001, 0); wr(0, 'h77);
    chk(cur_addr[15:0], 'h3377, "R13 written byte over engine value");
    chk(base_addr[15:0], 'h1277, "R13 base byte write");
    wr(12, 0);

    // R10: temporary register and master clear
    eng_temp_we = 1; eng_temp = 'hA5; cyc(0, 0, 0, 0);
    rd(13); chk(io_rdata, 'hA5, "R10 temporary read");
    wr(0, 'h11);
    wr(13, 0);
    chk(ch_mask, 4'hF, "R10 masks set");
    chk(cmd_reg, 0, "R10 command cleared");
    chk(req_pend, 0, "R10 request cleared");
    chk(ch_mode[23:18], 'h30, "R10 mode kept");
    rd(13); chk(io_rdata, 0, "R10 temporary cleared");
    rd(8);  chk(io_rdata, 0, "R10 status cleared");
    wr(0, 'h22); chk(base_addr[15:0], 'h1222, "R10 pointer cleared");

    // R12: unmapped reads and hold
    rd(0); rd(9); chk(io_rdata, 0, "R12 unmapped read zero");
    rd(4); cyc(0, 0, 0, 0);
    chk(io_rdata, 'h00, "R12 data held");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule